// File: doc/BRIEF.md
# Scattered-Bit Signature Sequence Checker

This block proves that a finite state machine carries an ownership mark spread thinly across its outputs. When a start pulse arrives, the checker holds the machine under test in synchronous reset for one cycle. This brings the machine to its known starting state. The checker then plays a fixed list of input vectors into the machine, one vector per clock. Each output word that comes back is treated as a slice of one long flat bit stream.

Only a parameterised set of scattered positions in that stream carries signature bits. Every other output bit is ignored. The checker counts how many listed positions disagree with the stored signature. At the end of the run it gives a one-cycle completion pulse together with a pass flag and the mismatch count. The input vectors, positions and signature are all parameters, so one checker instance is tied to one marked design.

Top module: `wmk_sig_check`

## Requirements
- R1: After reset, `done`, `pass`, `miss_count`, `mut_rst` and `mut_in` are all 0.
- R2: A `start` sampled high while the checker is idle makes `mut_rst` high in the following cycle, for exactly one cycle.
- R3: In the STEPS cycles right after the `mut_rst` cycle, `mut_in` carries vector i (i = 1..STEPS), taken from bits [(i-1)*IN_W +: IN_W] of `VECTORS`. At all other times `mut_in` is 0.
- R4: The output word produced by vector i is sampled one cycle after vector i is driven. Flat position p (1-based) names word (p-1)/OUT_W + 1, at bit (p-1)%OUT_W of `mut_out`, counting from the LSB. Position l of the list is bits [(l-1)*POS_W +: POS_W] of `POSITIONS`. Its signature bit is bit l-1 of `SIGNATURE`.
- R5: `miss_count` equals the number of listed positions whose sampled output bit differs from its signature bit. It never exceeds SIG_BITS.
- R6: Output bits at unlisted positions have no effect on `miss_count` or `pass`.
- R7: `done` is high for exactly one cycle. That cycle is the one after the last word is sampled, i.e. STEPS+3 cycles after the cycle in which `start` was sampled.
- R8: `pass` is 1 exactly when the completed run found zero mismatches. `pass` and `miss_count` hold their values until the next accepted start.
- R9: A `start` that arrives while a run is in progress (reset, drive or final sample cycle) is ignored. It neither restarts the run nor triggers a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the checker |
| start | input | 1 | Begin a check run when idle |
| mut_rst | output | 1 | Synchronous reset to the machine under test |
| mut_in | output | IN_W | Input vector applied to the machine under test |
| mut_out | input | OUT_W | Registered output word from the machine under test |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | 1 when the last run had no mismatch |
| miss_count | output | $clog2(SIG_BITS+1) | Mismatches found by the last run |

## Verification
The bench uses the default parameters: 1-bit inputs, 3-bit output words, eight vectors and eight signature bits. The listed positions land in all eight words and in every bit lane of a word. This means a wrong word index or a swapped bit order would flip the verdict.

The bench also contains a three-state machine whose output table can be switched between four variants:
- a correct copy, which passes;
- a copy with one listed bit wrong, which must give a count of exactly one;
- a copy that alters only unlisted bits, which must still pass;
- a fully inverted copy, which must give the largest possible count.

// File: rtl/wmk_pkg.sv
package wmk_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PRIME = 2'd1,
    PH_DRIVE = 2'd2,
    PH_TAIL  = 2'd3
  } wmk_phase_e;

  // Flat 1-based position -> 0-based word index
  function automatic int pos_word(input int p, input int k);
    return (p - 1) / k;
  endfunction

  // Flat 1-based position -> bit index inside the word (LSB = first bit)
  function automatic int pos_bit(input int p, input int k);
    return (p - 1) % k;
  endfunction

endpackage

// File: rtl/wmk_seq_ctrl.sv
module wmk_seq_ctrl
  import wmk_pkg::*;
#(
  parameter int STEPS = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output wmk_phase_e       phase,
  output logic [IDX_W-1:0] drv_idx,
  output logic             chk_vld,
  output logic [IDX_W-1:0] chk_idx
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(STEPS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      drv_idx <= '0;
      chk_vld <= 1'b0;
      chk_idx <= '0;
    end else begin
      chk_vld <= (phase == PH_DRIVE);
      chk_idx <= drv_idx;
      unique case (phase)
        PH_IDLE:  if (start) phase <= PH_PRIME;
        PH_PRIME: begin
          phase   <= PH_DRIVE;
          drv_idx <= '0;
        end
        PH_DRIVE: begin
          if (drv_idx == LAST) phase <= PH_TAIL;
          else                 drv_idx <= drv_idx + 1'b1;
        end
        PH_TAIL:  phase <= PH_IDLE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wmk_word_cmp.sv
module wmk_word_cmp
  import wmk_pkg::*;
#(
  parameter int                       OUT_W     = 3,
  parameter int                       SIG_BITS  = 8,
  parameter int                       POS_W     = 8,
  parameter int                       IDX_W     = 3,
  parameter int                       CNT_W     = 4,
  parameter logic [SIG_BITS*POS_W-1:0] POSITIONS = '0,
  parameter logic [SIG_BITS-1:0]       SIGNATURE = '0
) (
  input  logic                chk_vld,
  input  logic [IDX_W-1:0]    chk_idx,
  input  logic [OUT_W-1:0]    word,
  output logic [SIG_BITS-1:0] miss_vec,
  output logic [CNT_W-1:0]    word_miss
);

  for (genvar l = 0; l < SIG_BITS; l++) begin : g_pos
    localparam int P  = int'(POSITIONS[l*POS_W +: POS_W]);
    localparam int WI = pos_word(P, OUT_W);
    localparam int BI = pos_bit(P, OUT_W);
    logic hit;
    assign hit         = chk_vld && (chk_idx == IDX_W'(WI));
    assign miss_vec[l] = hit && (word[BI] != SIGNATURE[l]);
  end

  always_comb begin
    word_miss = '0;
    for (int l = 0; l < SIG_BITS; l++)
      word_miss = word_miss + CNT_W'(miss_vec[l]);
  end

endmodule

// File: rtl/wmk_tally.sv
module wmk_tally #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             add_en,
  input  logic [CNT_W-1:0] add_val,
  input  logic             finish,
  output logic [CNT_W-1:0] count,
  output logic             done,
  output logic             pass
);

  logic [CNT_W-1:0] next_count;
  assign next_count = add_en ? count + add_val : count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      done  <= 1'b0;
      pass  <= 1'b0;
    end else begin
      done <= finish;
      if (clear) begin
        count <= '0;
        pass  <= 1'b0;
      end else begin
        count <= next_count;
        if (finish) pass <= (next_count == '0);
      end
    end
  end

endmodule

// File: rtl/wmk_sig_check.sv
module wmk_sig_check
  import wmk_pkg::*;
#(
  parameter int                        IN_W      = 1,
  parameter int                        OUT_W     = 3,
  parameter int                        STEPS     = 8,
  parameter int                        SIG_BITS  = 8,
  parameter int                        POS_W     = 8,
  parameter logic [STEPS*IN_W-1:0]     VECTORS   = 8'h18,
  parameter logic [SIG_BITS*POS_W-1:0] POSITIONS =
    {8'd4, 8'd17, 8'd23, 8'd20, 8'd10, 8'd2, 8'd13, 8'd9},
  parameter logic [SIG_BITS-1:0]       SIGNATURE = 8'h15,
  localparam int CNT_W = $clog2(SIG_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             mut_rst,
  output logic [IN_W-1:0]  mut_in,
  input  logic [OUT_W-1:0] mut_out,
  output logic             done,
  output logic             pass,
  output logic [CNT_W-1:0] miss_count
);

  localparam int IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1;

  wmk_phase_e          phase;
  logic [IDX_W-1:0]    drv_idx;
  logic                chk_vld;
  logic [IDX_W-1:0]    chk_idx;
  logic [SIG_BITS-1:0] miss_vec;
  logic [CNT_W-1:0]    word_miss;

  // Named events for the checker
  logic busy, accept, drive_en, last_chk;
  assign busy     = (phase != PH_IDLE);
  assign accept   = start && !busy;
  assign drive_en = (phase == PH_DRIVE);
  assign last_chk = chk_vld && (chk_idx == IDX_W'(STEPS - 1));

  wmk_seq_ctrl #(.STEPS(STEPS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .phase(phase),
    .drv_idx(drv_idx), .chk_vld(chk_vld), .chk_idx(chk_idx)
  );

  assign mut_rst = (phase == PH_PRIME);

  always_comb begin
    mut_in = '0;
    if (drive_en) mut_in = VECTORS[int'(drv_idx)*IN_W +: IN_W];
  end

  wmk_word_cmp #(
    .OUT_W(OUT_W), .SIG_BITS(SIG_BITS), .POS_W(POS_W), .IDX_W(IDX_W),
    .CNT_W(CNT_W), .POSITIONS(POSITIONS), .SIGNATURE(SIGNATURE)
  ) u_cmp (
    .chk_vld(chk_vld), .chk_idx(chk_idx), .word(mut_out),
    .miss_vec(miss_vec), .word_miss(word_miss)
  );

  wmk_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .clear(accept), .add_en(chk_vld),
    .add_val(word_miss), .finish(last_chk),
    .count(miss_count), .done(done), .pass(pass)
  );

endmodule

// File: rtl/wmk_sig_check_sva.sv
module wmk_sig_check_sva #(
  parameter int IN_W     = 1,
  parameter int SIG_BITS = 8,
  parameter int CNT_W    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             last_chk,
  input logic             mut_rst,
  input logic [IN_W-1:0]  mut_in,
  input logic             done,
  input logic             pass,
  input logic [CNT_W-1:0] miss_count
);

  p_prime_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> mut_rst);

  p_prime_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mut_rst |=> !mut_rst);

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mut_in == '0 && !mut_rst));

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    miss_count <= CNT_W'(SIG_BITS));

  p_done_follows_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last_chk |=> done);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_pass_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass == (miss_count == '0)));

  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(miss_count) && $stable(pass)));

  p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !mut_rst);

endmodule

bind wmk_sig_check wmk_sig_check_sva #(
  .IN_W(IN_W), .SIG_BITS(SIG_BITS), .CNT_W(CNT_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .last_chk(last_chk), .mut_rst(mut_rst), .mut_in(mut_in),
  .done(done), .pass(pass), .miss_count(miss_count)
);

// File: tb/sim_wmk_sig_check.sv
module sim_wmk_sig_check;

  localparam int STEPS = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       mut_rst;
  logic [0:0] mut_in;
  logic [2:0] mut_out;
  logic       done, pass;
  logic [3:0] miss_count;
  int         mode = 0;

  int checks = 0;
  int fails  = 0;
  bit summary_done = 0;

  always #10 clk = ~clk;  // 50 MHz

  wmk_sig_check u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mut_rst(mut_rst),
    .mut_in(mut_in), .mut_out(mut_out), .done(done), .pass(pass),
    .miss_count(miss_count)
  );

  // Three-state machine under test, registered Mealy output.
  // mode 0: marked, 1: one listed bit wrong, 2: only unlisted bits changed, 3: all outputs inverted
  logic [1:0] st;
  function automatic logic [2:0] lam(input logic [1:0] s, input logic x, input int md);
    logic [2:0] y;
    case (s)
      2'd0:    y = x ? 3'b000 : 3'b010;
      2'd1:    y = x ? 3'b010 : 3'b100;
      default: y = x ? 3'b011 : 3'b101;
    endcase
    if (md == 1 && s == 2'd2 && !x) y = 3'b001;
    if (md == 2 && x && s != 2'd2)  y = 3'b110;
    if (md == 3) y = ~y;
    return y;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || mut_rst) begin
      st      <= 2'd0;
      mut_out <= 3'b000;
    end else begin
      mut_out <= lam(st, mut_in[0], mode);
      st      <= (st == 2'd2) ? 2'd0 : st + 2'd1;
    end
  end

  localparam bit XSEQ [STEPS] = '{0, 0, 0, 1, 1, 0, 0, 0};
  // mode, expected count, expected pass
  localparam int TBL [4][3] = '{'{0, 0, 1}, '{1, 1, 0}, '{2, 0, 1}, '{3, 8, 0}};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Full run; busy_kick injects a start at drive step busy_kick (-1: none)
  task automatic run(input int md, input int exp_cnt, input int exp_pass, input int busy_kick);
    mode = md;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R2 reset pulse", int'(mut_rst), 1);
    for (int i = 0; i < STEPS; i++) begin
      if (i == busy_kick) start = 1'b1;
      @(negedge clk); start = 1'b0;
      check("R3 vector", int'(mut_in), int'(XSEQ[i]));
      check("R2 single reset", int'(mut_rst), 0);
    end
    if (busy_kick >= 0) start = 1'b1;  // also kick during final sample cycle
    @(negedge clk); start = 1'b0;
    check("R7 no early done", int'(done), 0);
    @(negedge clk);
    check("R7 done", int'(done), 1);
    check("R5 count", int'(miss_count), exp_cnt);
    check("R8 pass", int'(pass), exp_pass);
    @(negedge clk);
    check("R7 done width", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 done", int'(done), 0);
    check("R1 pass", int'(pass), 0);
    check("R1 count", int'(miss_count), 0);
    check("R1 mut_rst", int'(mut_rst), 0);
    check("R1 mut_in", int'(mut_in), 0);

    // Table walk: R4 R5 R6 R8
    for (int t = 0; t < 4; t++)
      run(TBL[t][0], TBL[t][1], TBL[t][2], -1);

    // R8 hold: results persist while idle
    repeat (4) @(negedge clk);
    check("R8 hold count", int'(miss_count), 8);
    check("R8 hold pass", int'(pass), 0);

    // R9: starts during a run are ignored
    run(0, 0, 1, 3);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check("R9 no restart", int'(mut_rst), 0);
      check("R9 no second done", int'(done), 0);
    end
    check("R6 R9 pass kept", int'(pass), 1);

    finish_run();
  end

endmodule